// File: doc/BRIEF.md
# SMBus block transfer engine

This block is the block-data section of an SMBus host controller. It moves a payload of 1 to 32 bytes between the host side and a byte-level serial engine, which generates start, stop, byte transmission and byte reception with a chosen acknowledge. The serial engine itself is not part of this block. Software sets up the target address, the command byte, the length, and the direction, then pulses `start`. The block then issues the full sequence of bus operations for an SMBus block write, an SMBus block read, or the I2C-style block read, in which the slave sends no count byte.

There are two ways to carry the payload, selected by `buf_mode`.

- **Buffered mode.** The payload sits in a 32-entry byte buffer. While the engine is idle, the host reaches this buffer through one pair of streams with an auto-incrementing pointer. The host fills the buffer before `start` for writes and drains it after `done` for reads.
- **Byte-by-byte mode.** Each data byte passes through the streams while the transfer runs. After every data byte the engine raises `byte_done` and holds the bus until software pulses `bd_clear`. For reads, `host_last` tells the engine that the next byte it receives is the final one.

Host streams follow valid/ready rules:
- A beat moves on a rising edge where both valid and ready are high.
- `wr_ready` and `rd_valid` depend only on state, never on the opposite handshake signal.
- A producer may hold valid low for any number of cycles.

The bus command channel follows the same rules. After an operation is accepted, the engine waits for one `bus_done` pulse, which must come at least one cycle after acceptance, before it issues the next operation.

Top module: `smbblk_engine`

## Requirements
- R1: At `start` in a write or an I2C-style read, a `data0` of 0 or above 32 sets `failed`, produces the `done` pulse, and issues no bus operation.
- R2: A block write issues these operations in order:
  1. START with byte {addr7,0}
  2. SEND `cmd_byte`
  3. SEND the count from `data0`
  4. SEND each of the first count payload bytes
  5. STOP

  Bus op codes are START=0, SEND=1, RECV_ACK=2, RECV_NACK=3, STOP=4.
- R3: In idle buffered mode:
  - Each accepted host write or read uses the entry at the pointer and then advances the pointer.
  - The pointer moves from entry 31 back to entry 0.
  - `ptr_rst` returns the pointer to 0.
  - A host access in the same cycle as `ptr_rst` uses entry 0 and leaves the pointer at 1.
- R4: A block read issues these operations in order:
  1. START {addr7,0}
  2. SEND `cmd_byte`
  3. START {addr7,1}
  4. RECV_ACK for the count byte, which appears on `count_out`
  5. Count data receives, all RECV_ACK except the last, which is RECV_NACK
  6. STOP

  In buffered mode the received bytes land in buffer entries 0 upward.
- R5: A received block-read count of 0 or above 32 sets `failed`, followed by exactly one RECV_NACK and then STOP.
- R6: An I2C-style read (`i2c_mode`=1) issues START {addr7,0}, SEND `data1` in place of the command byte, START {addr7,1}, and then `data0` receives with the last one NACKed. No count byte is received.
- R7: In byte-by-byte mode `byte_done` rises after each data byte. No further bus operation is issued until `bd_clear` is pulsed.
- R8: In a byte-by-byte read, if `host_last` is high at `start` or at a `bd_clear`, the next receive is RECV_NACK and the transfer then stops after its `bd_clear`.
- R9: Buffered mode never raises `byte_done`. Buffer entries beyond the count are never sent on the bus.
- R10: `done` is a one-cycle pulse at the end of every transfer. `busy` is high from the cycle after an accepted legal `start` until `done`.
- R11:
  - After reset, `busy`, `byte_done`, `failed` and `bus_valid` are low.
  - `wr_ready` and `rd_valid` are high only in idle buffered mode, or in byte-by-byte mode when the engine wants a byte or holds a received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | begin a transfer (accepted when idle) |
| is_read | input | 1 | 1 = read, 0 = write |
| i2c_mode | input | 1 | reads only: no count byte, command from data1 |
| buf_mode | input | 1 | 1 = buffered, 0 = byte-by-byte |
| addr7 | input | 7 | slave address |
| cmd_byte | input | 8 | command byte |
| data0 | input | 8 | count for writes and I2C-style reads |
| data1 | input | 8 | command byte for I2C-style reads |
| host_last | input | 1 | marks the next read byte as final (byte-by-byte) |
| bd_clear | input | 1 | acknowledges byte_done |
| ptr_rst | input | 1 | reset the buffer pointer |
| wr_valid | input | 1 | host write stream valid |
| wr_data | input | 8 | host write stream data |
| wr_ready | output | 1 | host write stream ready |
| rd_valid | output | 1 | host read stream valid |
| rd_data | output | 8 | host read stream data |
| rd_ready | input | 1 | host read stream ready |
| bus_valid | output | 1 | bus operation valid |
| bus_ready | input | 1 | serial engine accepts operation |
| bus_op | output | 3 | operation code |
| bus_wdata | output | 8 | byte for START/SEND |
| bus_done | input | 1 | operation finished |
| bus_rdata | input | 8 | received byte, valid with bus_done |
| busy | output | 1 | transfer in progress |
| done | output | 1 | end-of-transfer pulse |
| failed | output | 1 | last transfer failed |
| byte_done | output | 1 | byte handshake pending |
| count_out | output | 8 | transfer count (received count for block reads) |

## Verification
Two events can arrive in the same cycle and are both tested that way.

The first pair is `ptr_rst` and a host stream write. The bench drives both in one cycle after the pointer has moved. It then writes one more byte, resets the pointer, and reads back: the first byte must come from entry 0 and the second from entry 1.

The second pair is a `bd_clear` and a read-stream pop in a byte-by-byte read. The bench raises `host_last` together with both. The held byte must be delivered exactly once, and the bus log must show that the following receive is NACKed and is followed by STOP.

// File: rtl/smbblk_pkg.sv
package smbblk_pkg;

  typedef enum logic [2:0] {
    OP_START = 3'd0,
    OP_SEND  = 3'd1,
    OP_RACK  = 3'd2,
    OP_RNACK = 3'd3,
    OP_STOP  = 3'd4
  } bus_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_CMD, S_CNT, S_FETCH, S_WDATA,
    S_RADDR, S_RCNT, S_DUMP, S_RDATA, S_BD, S_STOP
  } seq_state_e;

endpackage

// File: rtl/smbblk_buf.sv
module smbblk_buf #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_rst,
  input  logic          host_we,
  input  logic          host_re,
  input  logic [W-1:0]  host_wdata,
  output logic [W-1:0]  host_rdata,
  input  logic          eng_we,
  input  logic [PW-1:0] eng_idx,
  input  logic [W-1:0]  eng_wdata,
  output logic [W-1:0]  eng_rdata
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] ptr;
  logic [PW-1:0] base;
  logic [PW-1:0] step;
  logic          touch;

  // a pointer reset in the same cycle as an access makes the access hit entry 0
  assign base  = ptr_rst ? '0 : ptr;
  assign step  = (base == PW'(DEPTH - 1)) ? '0 : base + 1'b1;
  assign touch = host_we | host_re;

  assign host_rdata = mem[base];
  assign eng_rdata  = mem[eng_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (touch)   ptr <= step;
    else if (ptr_rst) ptr <= '0;
  end

  always_ff @(posedge clk) begin
    if (host_we) mem[base] <= host_wdata;
    if (eng_we)  mem[eng_idx] <= eng_wdata;
  end

  assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_rst && !touch) |=> (ptr == '0));

  assert_ptr_same_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_rst && touch) |=> (ptr == PW'(1)));

endmodule

// File: rtl/smbblk_seq.sv
module smbblk_seq
  import smbblk_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int IDX_W   = $clog2(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_read,
  input  logic             i2c_mode,
  input  logic             buf_mode,
  input  logic [6:0]       addr7,
  input  logic [7:0]       cmd_byte,
  input  logic [7:0]       data0,
  input  logic [7:0]       data1,
  input  logic             host_last,
  input  logic             bd_clear,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic [2:0]       bus_op,
  output logic [7:0]       bus_wdata,
  input  logic             bus_done,
  input  logic [7:0]       bus_rdata,
  output logic [IDX_W-1:0] buf_idx,
  input  logic [7:0]       buf_rdata,
  output logic             buf_we,
  output logic [7:0]       buf_wdata,
  output logic             fetch_ready,
  input  logic             fetch_valid,
  input  logic [7:0]       fetch_data,
  output logic             hold_valid,
  output logic [7:0]       hold_data,
  input  logic             hold_pop,
  output logic             busy,
  output logic             done,
  output logic             failed,
  output logic             byte_done,
  output logic [7:0]       count_out
);

  seq_state_e       state;
  logic             issued;
  logic [IDX_W-1:0] idx;
  logic [7:0]       cnt;
  logic             rd_q, i2c_q, bm_q, last_q, end_q;
  logic [6:0]       addr_q;
  logic [7:0]       cmd_q, d1_q, tx_q, hold_q;
  logic             hold_v, bd_q, fail_q, done_q;
  logic             op_state, advance, at_last, nack_now;
  logic             start_bad;

  function automatic logic len_bad(input logic [7:0] n);
    return (n == 8'd0) || (n > 8'(MAX_LEN));
  endfunction

  assign at_last   = ((8'(idx) + 8'd1) == cnt);
  assign nack_now  = at_last | (!bm_q & last_q);
  assign advance   = issued & bus_done;
  assign start_bad = (!is_read || i2c_mode) && len_bad(data0);

  always_comb begin
    op_state  = 1'b1;
    bus_op    = OP_SEND;
    bus_wdata = 8'h00;
    unique case (state)
      S_ADDR:  begin bus_op = OP_START; bus_wdata = {addr_q, 1'b0}; end
      S_CMD:   bus_wdata = (rd_q && i2c_q) ? d1_q : cmd_q;
      S_CNT:   bus_wdata = cnt;
      S_WDATA: bus_wdata = bm_q ? buf_rdata : tx_q;
      S_RADDR: begin bus_op = OP_START; bus_wdata = {addr_q, 1'b1}; end
      S_RCNT:  bus_op = OP_RACK;
      S_DUMP:  bus_op = OP_RNACK;
      S_RDATA: bus_op = nack_now ? OP_RNACK : OP_RACK;
      S_STOP:  bus_op = OP_STOP;
      default: op_state = 1'b0;
    endcase
  end

  assign bus_valid   = op_state & !issued;
  assign buf_idx     = idx;
  assign buf_we      = advance && (state == S_RDATA) && bm_q;
  assign buf_wdata   = bus_rdata;
  assign fetch_ready = (state == S_FETCH);
  assign hold_valid  = hold_v;
  assign hold_data   = hold_q;
  assign busy        = (state != S_IDLE);
  assign done        = done_q;
  assign failed      = fail_q;
  assign byte_done   = bd_q;
  assign count_out   = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      issued <= 1'b0;
      idx    <= '0;
      cnt    <= 8'd0;
      rd_q   <= 1'b0;
      i2c_q  <= 1'b0;
      bm_q   <= 1'b0;
      last_q <= 1'b0;
      end_q  <= 1'b0;
      addr_q <= 7'd0;
      cmd_q  <= 8'd0;
      d1_q   <= 8'd0;
      tx_q   <= 8'd0;
      hold_q <= 8'd0;
      hold_v <= 1'b0;
      bd_q   <= 1'b0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (hold_pop) hold_v <= 1'b0;
      if (bus_valid && bus_ready) issued <= 1'b1;
      if (advance) issued <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          rd_q   <= is_read;
          i2c_q  <= i2c_mode;
          bm_q   <= buf_mode;
          last_q <= host_last;
          end_q  <= 1'b0;
          addr_q <= addr7;
          cmd_q  <= cmd_byte;
          d1_q   <= data1;
          idx    <= '0;
          cnt    <= data0;
          fail_q <= start_bad;
          if (start_bad) done_q <= 1'b1;
          else           state  <= S_ADDR;
        end
        S_ADDR:  if (advance) state <= S_CMD;
        S_CMD:   if (advance) state <= rd_q ? S_RADDR : S_CNT;
        S_CNT:   if (advance) state <= bm_q ? S_WDATA : S_FETCH;
        S_FETCH: if (fetch_valid) begin
          tx_q  <= fetch_data;
          state <= S_WDATA;
        end
        S_WDATA: if (advance) begin
          if (!bm_q) begin
            bd_q  <= 1'b1;
            state <= S_BD;
          end else if (at_last) begin
            state <= S_STOP;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_RADDR: if (advance) state <= i2c_q ? S_RDATA : S_RCNT;
        S_RCNT: if (advance) begin
          cnt <= bus_rdata;
          if (len_bad(bus_rdata)) begin
            fail_q <= 1'b1;
            state  <= S_DUMP;
          end else begin
            state  <= S_RDATA;
          end
        end
        S_DUMP: if (advance) state <= S_STOP;
        S_RDATA: if (advance) begin
          if (bm_q) begin
            if (nack_now) state <= S_STOP;
            else          idx   <= idx + 1'b1;
          end else begin
            hold_q <= bus_rdata;
            hold_v <= 1'b1;
            bd_q   <= 1'b1;
            end_q  <= nack_now;
            state  <= S_BD;
          end
        end
        S_BD: if (bd_clear) begin
          bd_q   <= 1'b0;
          last_q <= host_last;
          if (rd_q ? end_q : at_last) begin
            state <= S_STOP;
          end else begin
            idx   <= idx + 1'b1;
            state <= rd_q ? S_RDATA : S_FETCH;
          end
        end
        S_STOP: if (advance) begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_bd_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bd_q |-> !bus_valid);

  assert_buf_no_bd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_q && state != S_IDLE) |-> !bd_q);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_nack_then_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && state == S_RDATA && bus_op == OP_RNACK) |=>
      (state == S_STOP || state == S_BD));

endmodule

// File: rtl/smbblk_engine.sv
module smbblk_engine #(
  parameter int MAX_LEN = 32,
  parameter int IDX_W   = $clog2(MAX_LEN)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       is_read,
  input  logic       i2c_mode,
  input  logic       buf_mode,
  input  logic [6:0] addr7,
  input  logic [7:0] cmd_byte,
  input  logic [7:0] data0,
  input  logic [7:0] data1,
  input  logic       host_last,
  input  logic       bd_clear,
  input  logic       ptr_rst,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       wr_ready,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  input  logic       rd_ready,
  output logic       bus_valid,
  input  logic       bus_ready,
  output logic [2:0] bus_op,
  output logic [7:0] bus_wdata,
  input  logic       bus_done,
  input  logic [7:0] bus_rdata,
  output logic       busy,
  output logic       done,
  output logic       failed,
  output logic       byte_done,
  output logic [7:0] count_out
);

  logic             idle_bm;
  logic             host_we, host_re;
  logic [7:0]       host_rdata;
  logic             eng_we;
  logic [IDX_W-1:0] eng_idx;
  logic [7:0]       eng_wdata, eng_rdata;
  logic             fetch_ready, hold_valid, hold_pop;
  logic [7:0]       hold_data;

  // host port reaches the buffer only while idle in buffered mode
  assign idle_bm  = !busy && buf_mode;
  assign wr_ready = idle_bm | fetch_ready;
  assign rd_valid = idle_bm | hold_valid;
  assign rd_data  = idle_bm ? host_rdata : hold_data;
  assign host_we  = idle_bm & wr_valid;
  assign host_re  = idle_bm & rd_ready;
  assign hold_pop = hold_valid & rd_ready;

  smbblk_buf #(.DEPTH(MAX_LEN), .W(8), .PW(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .ptr_rst(ptr_rst),
    .host_we(host_we), .host_re(host_re),
    .host_wdata(wr_data), .host_rdata(host_rdata),
    .eng_we(eng_we), .eng_idx(eng_idx),
    .eng_wdata(eng_wdata), .eng_rdata(eng_rdata)
  );

  smbblk_seq #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .is_read(is_read), .i2c_mode(i2c_mode), .buf_mode(buf_mode),
    .addr7(addr7), .cmd_byte(cmd_byte), .data0(data0), .data1(data1),
    .host_last(host_last), .bd_clear(bd_clear),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_op(bus_op),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
    .buf_idx(eng_idx), .buf_rdata(eng_rdata),
    .buf_we(eng_we), .buf_wdata(eng_wdata),
    .fetch_ready(fetch_ready), .fetch_valid(wr_valid), .fetch_data(wr_data),
    .hold_valid(hold_valid), .hold_data(hold_data), .hold_pop(hold_pop),
    .busy(busy), .done(done), .failed(failed),
    .byte_done(byte_done), .count_out(count_out)
  );

  assert_stream_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && buf_mode) |-> (!wr_ready && !hold_valid));

endmodule

// File: tb/smbblk_engine_bench.sv
module smbblk_engine_bench;

  localparam logic [6:0] ADDR = 7'h2C;
  localparam logic [7:0] CMD  = 8'h5A;
  localparam logic [7:0] D1   = 8'hC3;
  localparam int NV = 10;
  // {rd, i2c, expected fail, length}
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 8'd4},  {1'b0, 1'b0, 1'b0, 8'd32},
    {1'b0, 1'b0, 1'b1, 8'd0},  {1'b0, 1'b0, 1'b1, 8'd40},
    {1'b1, 1'b0, 1'b0, 8'd3},  {1'b1, 1'b0, 1'b0, 8'd32},
    {1'b1, 1'b0, 1'b1, 8'd0},  {1'b1, 1'b0, 1'b1, 8'd33},
    {1'b1, 1'b1, 1'b0, 8'd5},  {1'b1, 1'b1, 1'b1, 8'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, is_read = 0, i2c_mode = 0, buf_mode = 0;
  logic [7:0] data0 = 0;
  logic host_last = 0, bd_clear = 0, ptr_rst = 0;
  logic wr_valid = 0, rd_ready = 0;
  logic [7:0] wr_data = 0;
  logic wr_ready, rd_valid, bus_valid, busy, done, failed, byte_done;
  logic [7:0] rd_data, bus_wdata, count_out;
  logic [2:0] bus_op;
  logic bus_done = 0;
  logic [7:0] bus_rdata = 0;

  int total = 0, bad = 0, cyc = 0;
  int log_op[128], log_dat[128], n_log = 0;
  int exp_op[128], exp_dat[128], n_exp = 0;
  logic [7:0] rx_mem[64];
  int rx_i = 0, dly = 0, pend = 0;
  int done_cnt = 0;
  bit bd_seen = 0, gate_bad = 0, busy_seen = 0;

  always #2 clk = ~clk;

  smbblk_engine u_smbblk_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read),
    .i2c_mode(i2c_mode), .buf_mode(buf_mode), .addr7(ADDR), .cmd_byte(CMD),
    .data0(data0), .data1(D1), .host_last(host_last), .bd_clear(bd_clear),
    .ptr_rst(ptr_rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ready(rd_ready), .bus_valid(bus_valid), .bus_ready(1'b1),
    .bus_op(bus_op), .bus_wdata(bus_wdata), .bus_done(bus_done),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .failed(failed),
    .byte_done(byte_done), .count_out(count_out)
  );

  // serial engine model: accepts at once, finishes two cycles later
  always @(posedge clk) begin
    bus_done <= 1'b0;
    if (dly > 0) begin
      dly = dly - 1;
      if (dly == 0) begin
        bus_done <= 1'b1;
        if (pend == 2 || pend == 3) begin
          bus_rdata <= rx_mem[rx_i];
          rx_i = rx_i + 1;
        end
      end
    end
    if (bus_valid) begin
      log_op[n_log] = int'(bus_op);
      log_dat[n_log] = int'(bus_wdata);
      n_log = n_log + 1;
      pend = int'(bus_op);
      dly = 2;
    end
    if (rst_n) begin
      if (byte_done && buf_mode) bd_seen = 1;
      if (done) done_cnt = done_cnt + 1;
      if (busy) busy_seen = 1;
      if (busy && buf_mode && (wr_ready || rd_valid)) gate_bad = 1;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [7:0] pat(int s, int k);
    return 8'(s * 16 + k * 7 + 1);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic add(int op, int dat);
    exp_op[n_exp] = op; exp_dat[n_exp] = dat; n_exp = n_exp + 1;
  endtask

  task automatic build_exp(bit rd, bit i2c, bit fl, int len, int s);
    n_exp = 0;
    if (!rd) begin
      if (fl) return;
      add(0, {ADDR, 1'b0}); add(1, CMD); add(1, len);
      for (int k = 0; k < len; k++) add(1, pat(s, k));
      add(4, -1);
    end else if (i2c) begin
      if (fl) return;
      add(0, {ADDR, 1'b0}); add(1, D1); add(0, {ADDR, 1'b1});
      for (int k = 0; k < len; k++) add(k == len - 1 ? 3 : 2, -1);
      add(4, -1);
    end else begin
      add(0, {ADDR, 1'b0}); add(1, CMD); add(0, {ADDR, 1'b1}); add(2, -1);
      if (fl) add(3, -1);
      else for (int k = 0; k < len; k++) add(k == len - 1 ? 3 : 2, -1);
      add(4, -1);
    end
  endtask

  task automatic cmp_log(string req);
    int at = -1;
    for (int k = 0; k < n_exp && k < n_log; k++)
      if (at < 0 && (log_op[k] != exp_op[k] ||
          (exp_dat[k] >= 0 && log_dat[k] != exp_dat[k]))) at = k;
    if (n_log != n_exp) chk(0, req, "bus op count", n_log, n_exp);
    else if (at >= 0) chk(0, req, $sformatf("bus op %0d (op*256+data)", at),
                          log_op[at] * 256 + log_dat[at], exp_op[at] * 256 + exp_dat[at]);
    else chk(1, req, "bus sequence", n_log, n_exp);
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk); wr_valid = 1; wr_data = b;
    while (!wr_ready) @(negedge clk);
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic pop(output logic [7:0] b);
    @(negedge clk);
    while (!rd_valid) @(negedge clk);
    b = rd_data; rd_ready = 1;
    @(negedge clk); rd_ready = 0;
  endtask

  task automatic pulse_ptr_rst();
    @(negedge clk); ptr_rst = 1; @(negedge clk); ptr_rst = 0;
  endtask

  task automatic go(bit rd, bit i2c, bit bm, int len);
    @(negedge clk);
    is_read = rd; i2c_mode = i2c; buf_mode = bm; data0 = 8'(len);
    n_log = 0; rx_i = 0; done_cnt = 0; bd_seen = 0; gate_bad = 0; busy_seen = 0;
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic wait_done(string req);
    int t = 0;
    while (done_cnt == 0 && t < 3000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, req, "done pulses (R10)", done_cnt, 1);
  endtask

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !byte_done && !failed && !bus_valid, "R11", "reset outputs",
        {busy, byte_done, failed, bus_valid}, 0);
    chk(!wr_ready && !rd_valid, "R11", "streams closed in idle byte mode",
        {wr_ready, rd_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !failed, "R11", "after reset release", {busy, failed}, 0);

    // table of buffered transactions
    for (int v = 0; v < NV; v++) begin
      bit rd = VEC[v][10], i2c = VEC[v][9], fl = VEC[v][8];
      int len = int'(VEC[v][7:0]);
      string req = fl ? (rd && !i2c ? "R5" : "R1") : (!rd ? "R2" : (i2c ? "R6" : "R4"));
      buf_mode = 1;
      pulse_ptr_rst();
      if (!rd) begin
        int np = (len < 10) ? 10 : (len > 32 ? 32 : len);
        for (int k = 0; k < np; k++) push(pat(v, k));
      end else begin
        int o = i2c ? 0 : 1;
        if (!i2c) rx_mem[0] = 8'(len);
        for (int k = 0; k < 40; k++) rx_mem[k + o] = pat(v, k);
      end
      build_exp(rd, i2c, fl, len, v);
      go(rd, i2c, 1'b1, len);
      wait_done(req);
      cmp_log(req);
      chk(failed == fl, req, "failed flag", failed, fl);
      chk(!bd_seen, "R9", "byte_done in buffered mode", bd_seen, 0);
      chk(!gate_bad, "R11", "streams closed while busy", gate_bad, 0);
      chk(busy_seen == !(fl && (!rd || i2c)), "R10", "busy during transfer",
          busy_seen, !(fl && (!rd || i2c)));
      if (rd && !i2c) chk(count_out == 8'(len), "R4", "received count", count_out, len);
      if (rd && !fl) begin
        int errs = 0;
        pulse_ptr_rst();
        for (int k = 0; k < len; k++) begin
          pop(b);
          if (b != pat(v, k)) errs++;
        end
        chk(errs == 0, req, "buffer readback mismatches", errs, 0);
      end
    end

    // R3 pointer wrap after entry 31
    buf_mode = 1;
    pulse_ptr_rst();
    for (int k = 0; k < 33; k++) push(8'(100 + k));
    pulse_ptr_rst();
    pop(b); chk(b == 8'd132, "R3", "entry 0 after wrap", b, 132);
    pop(b); chk(b == 8'd101, "R3", "entry 1 after wrap", b, 101);

    // R3 pointer reset and write in the same cycle
    @(negedge clk); ptr_rst = 1; wr_valid = 1; wr_data = 8'hAA;
    @(negedge clk); ptr_rst = 0; wr_valid = 0;
    push(8'hBB);
    pulse_ptr_rst();
    pop(b); chk(b == 8'hAA, "R3", "same-cycle write lands at 0", b, 8'hAA);
    pop(b); chk(b == 8'hBB, "R3", "pointer left at 1", b, 8'hBB);

    // R7 byte-by-byte write of three bytes
    build_exp(1'b0, 1'b0, 1'b0, 3, 11);
    go(1'b0, 1'b0, 1'b0, 3);
    for (int k = 0; k < 3; k++) begin
      int t = 0, held;
      push(pat(11, k));
      while (!byte_done && t < 200) begin @(negedge clk); t++; end
      held = n_log;
      repeat (8) @(negedge clk);
      chk(byte_done && n_log == held, "R7", $sformatf("bus stalled at byte %0d", k),
          n_log, held);
      @(negedge clk); bd_clear = 1; @(negedge clk); bd_clear = 0;
    end
    wait_done("R7");
    cmp_log("R7");

    // R8 byte-by-byte read ended early by host_last together with a pop
    rx_mem[0] = 8'd5;
    for (int k = 0; k < 8; k++) rx_mem[k + 1] = pat(12, k);
    n_exp = 0;
    add(0, {ADDR, 1'b0}); add(1, CMD); add(0, {ADDR, 1'b1});
    add(2, -1); add(2, -1); add(3, -1); add(4, -1);
    host_last = 0;
    go(1'b1, 1'b0, 1'b0, 0);
    for (int k = 0; k < 2; k++) begin
      int t = 0;
      while (!byte_done && t < 200) begin @(negedge clk); t++; end
      chk(rd_valid && rd_data == pat(12, k), "R8", $sformatf("held byte %0d", k),
          rd_data, pat(12, k));
      rd_ready = 1; bd_clear = 1; host_last = 1;
      @(negedge clk); rd_ready = 0; bd_clear = 0; host_last = 0;
      chk(!rd_valid, "R8", "held byte delivered once", rd_valid, 0);
    end
    wait_done("R8");
    cmp_log("R8");
    chk(!failed, "R8", "failed flag", failed, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule